// File: doc/BRIEF.md
# Vectored IRQ/FIQ Interrupt Controller

This block gathers a wide vector of level-sensitive interrupt lines and condenses them into two processor requests: a normal interrupt (IRQ) and a fast interrupt (FIQ). The lines are grouped into 32-bit banks. Each line passes through a two-flop synchronizer, and the synchronized level is the line's pending bit. A per-bit mask suppresses a source. A per-bit route register steers an unmasked source to the fast request as well as the normal one.

Software reaches the block through a simple 32-bit word bus inside a 1 KB window. Writes take effect at the clock edge. Reads return data in the same cycle from registered state. A vector register holds the byte offset (source number times four) of the lowest-numbered source that is both pending and unmasked. An interrupt handler can add this offset to a table base to dispatch.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: A source line's pending bit follows the line's level. A change on the line reaches the pending bit, and the IRQ/FIQ outputs, on the second rising clock edge after the change and not on the first.
- R2: `irq_o` is high exactly when some source is pending and its mask bit is 0, in any bank.
- R3: `fiq_o` is high exactly when some source is pending, unmasked and has its route bit set to 1.
- R4: A read at offset 0x000 returns 4 × (32 × bank + bit) for the lowest-numbered pending unmasked source. The search runs from bank 0 upward and from bit 0 upward. The read returns 0 when there is no such source.
- R5: The pending banks read at 0x010, 0x014 and 0x018 (bank = address bits [3:2]). Writes there are accepted and change nothing.
- R6: The FIQ-pending banks at 0x020, 0x024 and 0x028 are write-one-to-clear: each written 1 clears that bit, and each written 0 leaves it unchanged. The hardware never sets these bits, so after reset they read 0.
- R7: Offset 0x004 stores the written word with bits [1:0] forced to 0.
- R8: The route banks (0x030–0x038), enable banks (0x040–0x048) and mask banks (0x050–0x058), together with the words at 0x008 and 0x00C, are plain read/write storage. The enable banks do not gate either output.
- R9: After reset every register reads 0, and both `irq_o` and `fiq_o` are low.
- R10: Offsets that are undefined read 0 and ignore writes. These include a bank index of 3 in any group, any offset at or above 0x060, and any address with bits [1:0] not equal to 00.
- R11: A register write changes the outputs and the vector right after the edge that captures it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt lines, bit n is source n |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address within the 1 KB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong pending, mask or route bit always shows on `irq_o` or `fiq_o`, or in the vector read, by the first cycle after the stimulus that set it up. The bench therefore samples both request lines and the vector after every change of source or register. A fault in the priority scan shows as a wrong vector only when several sources are active at once. For this reason the sources are spread across banks and bit positions, and both the lowest and the highest source numbers are used. Storage and decode faults show on the next readback: bits [1:0] of the base word, the clear behaviour of the FIQ-pending banks, and aliasing at undefined offsets.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 10;

  // group codes taken from address bits [9:4]
  localparam logic [5:0] GRP_SINGLE = 6'h00;
  localparam logic [5:0] GRP_IPEND  = 6'h01;
  localparam logic [5:0] GRP_FPEND  = 6'h02;
  localparam logic [5:0] GRP_ROUTE  = 6'h03;
  localparam logic [5:0] GRP_ENA    = 6'h04;
  localparam logic [5:0] GRP_MASK   = 6'h05;

  typedef enum logic [3:0] {
    RG_NONE, RG_VEC, RG_BASE, RG_PROT, RG_NMI,
    RG_IPEND, RG_FPEND, RG_ROUTE, RG_ENA, RG_MASK
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [1:0] bank;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                       input int unsigned nbanks);
    dec_t d;
    d.region = RG_NONE;
    d.bank   = a[3:2];
    if (a[1:0] == 2'b00) begin
      if (a[9:4] == GRP_SINGLE) begin
        case (a[3:2])
          2'd0:    d.region = RG_VEC;
          2'd1:    d.region = RG_BASE;
          2'd2:    d.region = RG_PROT;
          default: d.region = RG_NMI;
        endcase
      end else if ({30'd0, a[3:2]} < nbanks) begin
        case (a[9:4])
          GRP_IPEND: d.region = RG_IPEND;
          GRP_FPEND: d.region = RG_FPEND;
          GRP_ROUTE: d.region = RG_ROUTE;
          GRP_ENA:   d.region = RG_ENA;
          GRP_MASK:  d.region = RG_MASK;
          default:   d.region = RG_NONE;
        endcase
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] lvl_q,  lvl_d;

  always_comb begin
    meta_d = d_i;
    lvl_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned WIDTH = 96,
  localparam int unsigned IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] act_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // scan downward so the lowest active index is the last assignment
  always_comb begin
    idx_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (act_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |act_i;
  end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned VEC_W     = 9,
  localparam int unsigned NUM_SRC  = NUM_BANKS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] route_o,
  output logic [WORD_W-1:0]  base_o
);
  dec_t dec;
  logic wr_en;

  assign dec   = decode_addr(bus_addr_i, NUM_BANKS);
  assign wr_en = bus_sel_i & bus_wr_i;

  // single words
  logic [WORD_W-1:0] base_q, base_d, prot_q, prot_d, nmi_q, nmi_d;

  always_comb begin
    base_d = base_q;
    prot_d = prot_q;
    nmi_d  = nmi_q;
    if (wr_en) begin
      case (dec.region)
        RG_BASE: base_d = {bus_wdata_i[WORD_W-1:2], 2'b00};
        RG_PROT: prot_d = bus_wdata_i;
        RG_NMI:  nmi_d  = bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else begin
      base_q <= base_d;
      prot_q <= prot_d;
      nmi_q  <= nmi_d;
    end
  end

  // banked words
  logic [WORD_W-1:0] fpend_q [NUM_BANKS];
  logic [WORD_W-1:0] route_q [NUM_BANKS];
  logic [WORD_W-1:0] ena_q   [NUM_BANKS];
  logic [WORD_W-1:0] mask_q  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              hit;
    logic [WORD_W-1:0] fpend_d, route_d, ena_d, mask_d;

    assign hit = wr_en && (dec.bank == 2'(b));

    always_comb begin
      fpend_d = fpend_q[b];
      route_d = route_q[b];
      ena_d   = ena_q[b];
      mask_d  = mask_q[b];
      if (hit) begin
        case (dec.region)
          RG_FPEND: fpend_d = fpend_q[b] & ~bus_wdata_i;
          RG_ROUTE: route_d = bus_wdata_i;
          RG_ENA:   ena_d   = bus_wdata_i;
          RG_MASK:  mask_d  = bus_wdata_i;
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fpend_q[b] <= '0;
        route_q[b] <= '0;
        ena_q[b]   <= '0;
        mask_q[b]  <= '0;
      end else begin
        fpend_q[b] <= fpend_d;
        route_q[b] <= route_d;
        ena_q[b]   <= ena_d;
        mask_q[b]  <= mask_d;
      end
    end

    assign mask_o[b*WORD_W +: WORD_W]  = mask_q[b];
    assign route_o[b*WORD_W +: WORD_W] = route_q[b];
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (dec.region)
        RG_VEC:  bus_rdata_o = WORD_W'(vec_i);
        RG_BASE: bus_rdata_o = base_q;
        RG_PROT: bus_rdata_o = prot_q;
        RG_NMI:  bus_rdata_o = nmi_q;
        default: begin
          for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.bank == 2'(b)) begin
              case (dec.region)
                RG_IPEND: bus_rdata_o = pend_i[b*WORD_W +: WORD_W];
                RG_FPEND: bus_rdata_o = fpend_q[b];
                RG_ROUTE: bus_rdata_o = route_q[b];
                RG_ENA:   bus_rdata_o = ena_q[b];
                RG_MASK:  bus_rdata_o = mask_q[b];
                default:  ;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign base_o = base_q;
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  localparam int unsigned NUM_SRC  = NUM_BANKS * WORD_W,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC),
  localparam int unsigned VEC_W    = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0] pend_w, mask_w, route_w, live_w;
  logic [IDX_W-1:0]   idx_w;
  logic               any_w;
  logic [VEC_W-1:0]   vec_w;
  logic [WORD_W-1:0]  base_w;

  irqc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (src_i),
    .q_o   (pend_w)
  );

  assign live_w = pend_w & ~mask_w;

  irqc_prio #(.WIDTH(NUM_SRC)) u_prio (
    .act_i (live_w),
    .idx_o (idx_w),
    .any_o (any_w)
  );

  assign vec_w = {idx_w, 2'b00};

  irqc_regs #(.NUM_BANKS(NUM_BANKS), .VEC_W(VEC_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_i      (pend_w),
    .vec_i       (vec_w),
    .mask_o      (mask_w),
    .route_o     (route_w),
    .base_o      (base_w)
  );

  assign irq_o = any_w;
  assign fiq_o = |(live_w & route_w);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NUM_SRC = 96,
  parameter int unsigned VEC_W   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask,
  input logic [VEC_W-1:0]   vec,
  input logic [31:0]        base,
  input logic               irq,
  input logic               fiq,
  input logic               sel,
  input logic               wr,
  input logic [9:0]         addr,
  input logic [31:0]        wdata
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (pend == $past(src, 2)));

  // R3
  fiq_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> irq);

  // R4
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec == '0));

  // R4
  vec_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend[vec[VEC_W-1:2]] && !mask[vec[VEC_W-1:2]]));

  // R7
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base[1:0] == 2'b00);

  // R8
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == 10'h050) |=> (mask[31:0] == $past(wdata)));
endmodule

bind irq_fiq_ctrl irqc_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .src   (src_i),
  .pend  (pend_w),
  .mask  (mask_w),
  .vec   (vec_w),
  .base  (base_w),
  .irq   (irq_o),
  .fiq   (fiq_o),
  .sel   (bus_sel_i),
  .wr    (bus_wr_i),
  .addr  (bus_addr_i),
  .wdata (bus_wdata_i)
);

// File: tb/tb_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fiq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_fiq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic set_src(input logic [95:0] v);
    @(negedge clk);
    src = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R9 irq after reset", 32'(irq), 32'd0);
    check("R9 fiq after reset", 32'(fiq), 32'd0);
    for (int a = 0; a < 'h60; a += 4) begin
      bus_read(10'(a), d);
      check($sformatf("R9 reset readback @%0h", a), d, 32'd0);
    end
  endtask

  task automatic t_latency;
    logic [31:0] d;
    @(negedge clk);
    src[5] = 1'b1;
    @(posedge clk); #1;
    check("R1 not after first edge", 32'(irq), 32'd0);
    @(posedge clk); #1;
    check("R1 after second edge", 32'(irq), 32'd1);
    bus_read(10'h010, d);
    check("R1 pending bank0", d, 32'h20);
    bus_read(10'h000, d);
    check("R4 vector single", d, 32'd20);
    set_src('0);
    check("R1 level drop clears irq", 32'(irq), 32'd0);
    bus_read(10'h010, d);
    check("R1 pending cleared", d, 32'h0);
  endtask

  task automatic t_order;
    logic [95:0] v;
    logic [31:0] d;
    v = '0; v[33] = 1'b1; v[40] = 1'b1; v[70] = 1'b1;
    set_src(v);
    bus_read(10'h014, d);
    check("R5 pending bank1", d, 32'h102);
    bus_read(10'h018, d);
    check("R5 pending bank2", d, 32'h40);
    bus_read(10'h000, d);
    check("R4 lowest of three", d, 32'd132);
    check("R2 irq with sources", 32'(irq), 32'd1);
    check("R3 no route no fiq", 32'(fiq), 32'd0);
    bus_write(10'h054, 32'h2);
    // R11: visible right after the capturing edge
    bus_read(10'h000, d);
    check("R11 R4 vector after mask", d, 32'd160);
    bus_write(10'h038, 32'h40);
    check("R3 routed source raises fiq", 32'(fiq), 32'd1);
    bus_write(10'h058, 32'h40);
    check("R3 masked route drops fiq", 32'(fiq), 32'd0);
    check("R2 irq still from bit 40", 32'(irq), 32'd1);
    bus_write(10'h054, 32'h102);
    check("R2 all masked irq low", 32'(irq), 32'd0);
    bus_read(10'h000, d);
    check("R4 vector zero when none", d, 32'd0);
    bus_write(10'h054, 32'h0);
    bus_write(10'h058, 32'h0);
    bus_write(10'h038, 32'h0);
    v = '0; v[95] = 1'b1;
    set_src(v);
    bus_read(10'h000, d);
    check("R4 highest source", d, 32'd380);
    set_src('0);
  endtask

  task automatic t_storage;
    logic [31:0] d;
    bus_write(10'h004, 32'hDEADBEEF);
    bus_read(10'h004, d);
    check("R7 base low bits cleared", d, 32'hDEADBEEC);
    bus_write(10'h008, 32'h12345677);
    bus_read(10'h008, d);
    check("R8 protect word", d, 32'h12345677);
    bus_write(10'h00C, 32'hA5A5A5A5);
    bus_read(10'h00C, d);
    check("R8 nmi word", d, 32'hA5A5A5A5);
    bus_write(10'h034, 32'hCAFEF00D);
    bus_read(10'h034, d);
    check("R8 route bank1", d, 32'hCAFEF00D);
    bus_write(10'h048, 32'h0F0F0F0F);
    bus_read(10'h048, d);
    check("R8 enable bank2", d, 32'h0F0F0F0F);
    bus_write(10'h034, 32'h0);
    src[3] = 1'b1;
    set_src(src);
    check("R8 enable zero does not gate irq", 32'(irq), 32'd1);
    bus_write(10'h010, 32'hFFFFFFFF);
    bus_read(10'h010, d);
    check("R5 pending write ignored", d, 32'h8);
    set_src('0);
    bus_write(10'h010, 32'hFFFFFFFF);
    check("R5 write sets no irq", 32'(irq), 32'd0);
    bus_write(10'h020, 32'hFFFFFFFF);
    bus_read(10'h020, d);
    check("R6 fiq pending after clear", d, 32'h0);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    bus_write(10'h050, 32'h11);
    bus_write(10'h05C, 32'hFFFFFFFF);
    bus_write(10'h052, 32'hFFFFFFFF);
    bus_write(10'h060, 32'hFFFFFFFF);
    bus_write(10'h3FC, 32'hFFFFFFFF);
    bus_read(10'h050, d);
    check("R10 mask bank0 untouched", d, 32'h11);
    bus_read(10'h05C, d);
    check("R10 bank3 reads zero", d, 32'h0);
    bus_read(10'h052, d);
    check("R10 misaligned reads zero", d, 32'h0);
    bus_read(10'h060, d);
    check("R10 above groups reads zero", d, 32'h0);
    bus_read(10'h3FC, d);
    check("R10 window top reads zero", d, 32'h0);
    bus_read(10'h01C, d);
    check("R10 pending bank3 zero", d, 32'h0);
    bus_read(10'h004, d);
    check("R10 base untouched", d, 32'hDEADBEEC);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_order();
    t_storage();
    t_undef();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule